// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block sits between a UART's character shifters and its FIFOs and handles in-band software flow control in both directions. On the transmit side it watches a halt request and a resume request, which the receive FIFO raises when its fill level crosses the programmed thresholds. In response it places the programmed stop (XOFF) or go (XON) characters on the line ahead of any queued data byte. On the receive side it compares each incoming character against the programmed XON and XOFF values. A match pauses or resumes the local transmitter and is dropped from the receive stream. An XOFF match can also raise an interrupt pulse.

Two 2-bit mode fields select the behaviour. Either side can be disabled. Each side can use the first or the second character set on its own. Each side can also use both sets together, in which case a flow event is the two-character pair "set-1 character then set-2 character". The baud generator and the shift registers are outside this block. Characters enter and leave through valid/ready or valid-only ports.

Top module: `swfc_top`

## Requirements
- R1: After a synchronous active-low reset: `tx_en` is 1, `fifo_wr_valid` is 0, `xoff_irq` is 0, and `tx_valid` is 0 while `src_valid` is 0.
- R2: With receive mode `cfg_mode[1:0]` = 00, every received character is written to the receive FIFO port one cycle after it is sampled, and `tx_en` stays 1.
- R3: With receive mode 10 (set 1) or 01 (set 2), a character equal to that set's XOFF clears `tx_en` on the next cycle and a character equal to its XON sets it again. Matched characters are not written. Characters of the other set are written unchanged.
- R4: With receive mode 11, XOFF1 followed directly by XOFF2 pauses, and XON1 followed directly by XON2 resumes. Neither character is written. A set-1 character followed by any other character is written, and then the other character is written, in arrival order. Received characters are at least two cycles apart.
- R5: An XOFF match pulses `xoff_irq` for one cycle, in the same cycle `tx_en` falls, if `xoff_irq_en` is 1. It stays 0 if `xoff_irq_en` is 0.
- R6: While `tx_en` is 0, no data byte from the source is passed on: `src_ready` and `tx_valid` stay 0 when no flow character is due. A byte already accepted by the shifter is unaffected.
- R7: With transmit mode `cfg_mode[3:2]` = 00, halt and resume requests insert nothing, and source bytes pass straight through.
- R8: With transmit mode 10 a halt sends XOFF1 and a later resume sends XON1. Mode 01 sends XOFF2 and XON2 instead. A pending flow character goes out before a source byte that is already waiting.
- R9: With transmit mode 11 a halt sends XOFF1 then XOFF2, and a resume sends XON1 then XON2, with the pair never split by a data byte.
- R10: A second halt after an XOFF has been sent sends nothing. A resume when no XOFF has been sent sends nothing.
- R11: A halt followed by a resume before the XOFF has been accepted by the shifter cancels both, so no flow character is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 4 | [3:2] transmit mode, [1:0] receive mode: 00 off, 01 set 2, 10 set 1, 11 both |
| xoff_irq_en | input | 1 | Enables the XOFF-received interrupt pulse |
| xon1_char | input | W | Go character, set 1 |
| xon2_char | input | W | Go character, set 2 |
| xoff1_char | input | W | Stop character, set 1 |
| xoff2_char | input | W | Stop character, set 2 |
| rx_valid | input | 1 | Received character strobe from the receive shifter |
| rx_data | input | W | Received character |
| fifo_wr_valid | output | 1 | Write strobe into the receive FIFO |
| fifo_wr_data | output | W | Character written into the receive FIFO |
| halt_req | input | 1 | Receive FIFO reached the halt threshold (pulse) |
| resume_req | input | 1 | Receive FIFO fell to the resume threshold (pulse) |
| src_valid | input | 1 | Transmit FIFO has a byte |
| src_data | input | W | Byte at the head of the transmit FIFO |
| src_ready | output | 1 | The byte at the head of the transmit FIFO is taken this cycle |
| tx_ready | input | 1 | Transmit shifter can take a character |
| tx_valid | output | 1 | Character offered to the transmit shifter |
| tx_data | output | W | Character offered to the transmit shifter |
| tx_en | output | 1 | 1 while the transmitter is not paused by a received XOFF |
| xoff_irq | output | 1 | One-cycle XOFF-received interrupt pulse |

## Verification
A received character sampled at one clock edge is written to the FIFO port one cycle later. The second character of a broken pair is written two cycles later. `tx_en` and `xoff_irq` change in that same cycle after the edge. A halt or resume sampled at an edge makes the flow character appear on `tx_data` in the following cycle, and it leaves when `tx_ready` accepts it at the next edge. The bench drives inputs one time unit after the rising edge and samples at the falling edge. The bench's scoreboards hold the expected FIFO writes and transmitted characters in order. Any extra, missing or reordered character shows up against the queue. The pause and interrupt levels are read in the cycle after the final character of a match is sampled.

// File: rtl/swfc_pkg.sv
// Shared definitions for the software flow controller.
// Assumes: a mode field is two bits wide and coded as below.
package swfc_pkg;

    // Flow-control mode of one direction
    typedef enum logic [1:0] {
        FC_OFF  = 2'b00,
        FC_SET2 = 2'b01,
        FC_SET1 = 2'b10,
        FC_BOTH = 2'b11
    } fc_mode_e;

endpackage

// File: rtl/swfc_rx_match.sv
// Receive-side matcher: compares incoming characters with the programmed
// go/stop characters, drops matched ones and forwards the rest to the
// receive FIFO. In paired mode a set-1 character is held for one arrival;
// if the next character does not complete the pair, the held character is
// written first and the new one follows a cycle later.
// Assumes: rx_valid is never high on two consecutive cycles.
module swfc_rx_match
    import swfc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic [W-1:0] xon1,
    input  logic [W-1:0] xon2,
    input  logic [W-1:0] xoff1,
    input  logic [W-1:0] xoff2,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    output logic         fwd_valid,
    output logic [W-1:0] fwd_data,
    output logic         hit_on,
    output logic         hit_off
);

    fc_mode_e     m;
    logic [W-1:0] on_c, off_c;
    logic         hold_v, hold_off, spill_v;
    logic [W-1:0] hold_d, spill_d;
    logic         n_hold_v, n_hold_off, n_spill_v, n_out_v;
    logic [W-1:0] n_hold_d, n_spill_d, n_out_d;

    // Pick the single-set characters for the active mode
    always_comb begin
        m     = fc_mode_e'(mode);
        on_c  = (m == FC_SET2) ? xon2  : xon1;
        off_c = (m == FC_SET2) ? xoff2 : xoff1;
    end

    // Decide match, hold, spill and FIFO write for this cycle
    always_comb begin
        hit_on     = 1'b0;
        hit_off    = 1'b0;
        n_out_v    = spill_v;
        n_out_d    = spill_d;
        n_spill_v  = 1'b0;
        n_spill_d  = spill_d;
        n_hold_v   = (m == FC_BOTH) ? hold_v : 1'b0;
        n_hold_off = hold_off;
        n_hold_d   = hold_d;
        if (rx_valid) begin
            case (m)
                FC_OFF: begin
                    n_out_v = 1'b1;
                    n_out_d = rx_data;
                end
                FC_SET1, FC_SET2: begin
                    if (rx_data == off_c) begin
                        hit_off = 1'b1;
                    end else if (rx_data == on_c) begin
                        hit_on = 1'b1;
                    end else begin
                        n_out_v = 1'b1;
                        n_out_d = rx_data;
                    end
                end
                default: begin
                    if (hold_v && hold_off && rx_data == xoff2) begin
                        hit_off  = 1'b1;
                        n_hold_v = 1'b0;
                    end else if (hold_v && !hold_off && rx_data == xon2) begin
                        hit_on   = 1'b1;
                        n_hold_v = 1'b0;
                    end else begin
                        if (hold_v) begin
                            n_out_v = 1'b1;
                            n_out_d = hold_d;
                        end
                        if (rx_data == xoff1 || rx_data == xon1) begin
                            n_hold_v   = 1'b1;
                            n_hold_off = (rx_data == xoff1);
                            n_hold_d   = rx_data;
                        end else begin
                            n_hold_v = 1'b0;
                            if (hold_v) begin
                                n_spill_v = 1'b1;
                                n_spill_d = rx_data;
                            end else begin
                                n_out_v = 1'b1;
                                n_out_d = rx_data;
                            end
                        end
                    end
                end
            endcase
        end
    end

    // Register the hold/spill state and the FIFO write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v    <= 1'b0;
            hold_off  <= 1'b0;
            hold_d    <= '0;
            spill_v   <= 1'b0;
            spill_d   <= '0;
            fwd_valid <= 1'b0;
            fwd_data  <= '0;
        end else begin
            hold_v    <= n_hold_v;
            hold_off  <= n_hold_off;
            hold_d    <= n_hold_d;
            spill_v   <= n_spill_v;
            spill_d   <= n_spill_d;
            fwd_valid <= n_out_v;
            fwd_data  <= n_out_d;
        end
    end

    // R2: with matching off, every character reaches the FIFO next cycle
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mode == 2'b00) |=> (fwd_valid && fwd_data == $past(rx_data)));

    // R4: input spacing that the hold/spill scheme relies on
    a_r4_rx_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R4: a completed pair writes nothing to the FIFO
    a_r4_pair_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mode == 2'b11 && hold_v && hold_off && rx_data == xoff2)
        |=> !fwd_valid);

endmodule

// File: rtl/swfc_pause_ctrl.sv
// Pause state of the local transmitter and the XOFF-received interrupt.
// Assumes: hit_on and hit_off are single-cycle match strobes.
module swfc_pause_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rx_mode,
    input  logic       hit_on,
    input  logic       hit_off,
    input  logic       irq_en,
    output logic       paused,
    output logic       xoff_irq
);

    // Track pause from matches and pulse the interrupt on a stop match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused   <= 1'b0;
            xoff_irq <= 1'b0;
        end else begin
            xoff_irq <= hit_off && irq_en;
            if (rx_mode == 2'b00)
                paused <= 1'b0;
            else if (hit_off)
                paused <= 1'b1;
            else if (hit_on)
                paused <= 1'b0;
        end
    end

    // R5: the interrupt is a single-cycle pulse
    a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_irq |=> !xoff_irq);

    // R3: a go match always leaves the transmitter running
    a_r3_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_on && !hit_off) |=> !paused);

endmodule

// File: rtl/swfc_tx_insert.sv
// Transmit-side inserter: keeps the wanted line state (stopped or going)
// from halt/resume requests, and the state last sent. When they differ it
// offers the stop or go character(s) to the shifter ahead of source data.
// A pair started in mode 11 is always finished with the same kind.
// Assumes: the shifter accepts a character when tx_valid and tx_ready.
module swfc_tx_insert
    import swfc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic [W-1:0] xon1,
    input  logic [W-1:0] xon2,
    input  logic [W-1:0] xoff1,
    input  logic [W-1:0] xoff2,
    input  logic         halt_req,
    input  logic         resume_req,
    input  logic         paused,
    input  logic         src_valid,
    input  logic [W-1:0] src_data,
    output logic         src_ready,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic [W-1:0] tx_data
);

    fc_mode_e     m;
    logic         want_off, off_sent, mid, seq_off;
    logic         flow_act, kind, fire;
    logic [W-1:0] fc_char;

    // Select the flow character due now and mux it ahead of data
    always_comb begin
        m        = fc_mode_e'(mode);
        flow_act = (m != FC_OFF) && (mid || (want_off != off_sent));
        kind     = mid ? seq_off : want_off;
        case (m)
            FC_SET2: fc_char = kind ? xoff2 : xon2;
            FC_SET1: fc_char = kind ? xoff1 : xon1;
            FC_BOTH: fc_char = mid ? (kind ? xoff2 : xon2)
                                   : (kind ? xoff1 : xon1);
            default: fc_char = '0;
        endcase
        tx_valid  = flow_act || (!paused && src_valid);
        tx_data   = flow_act ? fc_char : src_data;
        src_ready = !flow_act && !paused && tx_ready;
        fire      = flow_act && tx_ready;
    end

    // Update wanted state, sent state and pair progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_off <= 1'b0;
            off_sent <= 1'b0;
            mid      <= 1'b0;
            seq_off  <= 1'b0;
        end else begin
            if (halt_req)
                want_off <= 1'b1;
            else if (resume_req)
                want_off <= 1'b0;
            if (m == FC_OFF) begin
                off_sent <= 1'b0;
                mid      <= 1'b0;
            end else if (fire) begin
                if (m == FC_BOTH && !mid) begin
                    mid     <= 1'b1;
                    seq_off <= want_off;
                end else begin
                    mid      <= 1'b0;
                    off_sent <= kind;
                end
            end
        end
    end

    // R9: the second character of a pair is offered right after the first
    a_r9_pair_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode == 2'b11 && !mid && mode == 2'b11) |=> (tx_valid || mode != 2'b11));

    // R7: with insertion off the shifter only ever sees source bytes
    a_r7_no_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && tx_valid) |-> (src_valid && tx_data == src_data));

    // R10: a stop is never sent again while the line is already stopped
    a_r10_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && kind && !mid && mode != 2'b11) |-> !off_sent);

endmodule

// File: rtl/swfc_top.sv
// XON/XOFF software flow controller top. Wires the receive matcher, the
// pause/interrupt state and the transmit inserter together.
// Assumes: cfg_mode and the flow characters are changed only while idle.
module swfc_top #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   cfg_mode,
    input  logic         xoff_irq_en,
    input  logic [W-1:0] xon1_char,
    input  logic [W-1:0] xon2_char,
    input  logic [W-1:0] xoff1_char,
    input  logic [W-1:0] xoff2_char,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    output logic         fifo_wr_valid,
    output logic [W-1:0] fifo_wr_data,
    input  logic         halt_req,
    input  logic         resume_req,
    input  logic         src_valid,
    input  logic [W-1:0] src_data,
    output logic         src_ready,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic [W-1:0] tx_data,
    output logic         tx_en,
    output logic         xoff_irq
);

    localparam int MODE_W = 2;

    logic [MODE_W-1:0] rx_mode, tx_mode;
    logic              hit_on, hit_off, paused;

    // Split the mode field into its two directions
    always_comb begin
        rx_mode = cfg_mode[MODE_W-1:0];
        tx_mode = cfg_mode[2*MODE_W-1:MODE_W];
        tx_en   = !paused;
    end

    swfc_rx_match #(.W(W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (rx_mode),
        .xon1     (xon1_char),
        .xon2     (xon2_char),
        .xoff1    (xoff1_char),
        .xoff2    (xoff2_char),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .fwd_valid(fifo_wr_valid),
        .fwd_data (fifo_wr_data),
        .hit_on   (hit_on),
        .hit_off  (hit_off)
    );

    swfc_pause_ctrl u_pause (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_mode (rx_mode),
        .hit_on  (hit_on),
        .hit_off (hit_off),
        .irq_en  (xoff_irq_en),
        .paused  (paused),
        .xoff_irq(xoff_irq)
    );

    swfc_tx_insert #(.W(W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (tx_mode),
        .xon1      (xon1_char),
        .xon2      (xon2_char),
        .xoff1     (xoff1_char),
        .xoff2     (xoff2_char),
        .halt_req  (halt_req),
        .resume_req(resume_req),
        .paused    (paused),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    // R6: a paused transmitter never takes a source byte
    a_r6_pause_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !src_ready);

    // R5: the interrupt pulse coincides with the paused state
    a_r5_irq_paused: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_irq |-> !tx_en);

endmodule

// File: tb/swfc_top_tb.sv
// Scoreboard bench for swfc_top: drivers push expected FIFO writes and
// transmitted characters into queues; monitors pop and compare.
module swfc_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam logic [7:0] ON1 = 8'h11, OFF1 = 8'h13, ON2 = 8'h91, OFF2 = 8'h93;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   cfg_mode = 4'h0;
    logic         xoff_irq_en = 1'b0;
    logic         rx_valid = 1'b0;
    logic [W-1:0] rx_data = '0;
    logic         fifo_wr_valid;
    logic [W-1:0] fifo_wr_data;
    logic         halt_req = 1'b0, resume_req = 1'b0;
    logic         src_valid = 1'b0;
    logic [W-1:0] src_data = '0;
    logic         src_ready;
    logic         tx_ready = 1'b1;
    logic         tx_valid;
    logic [W-1:0] tx_data;
    logic         tx_en, xoff_irq;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] exp_rx[$];
    logic [W-1:0] exp_tx[$];
    string tag_rx = "R2";
    string tag_tx = "R7";

    always #(CLK_PERIOD/2) clk = ~clk;

    swfc_top #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .xoff_irq_en(xoff_irq_en),
        .xon1_char(ON1), .xon2_char(ON2), .xoff1_char(OFF1), .xoff2_char(OFF2),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .fifo_wr_valid(fifo_wr_valid), .fifo_wr_data(fifo_wr_data),
        .halt_req(halt_req), .resume_req(resume_req),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_en(tx_en), .xoff_irq(xoff_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor of the receive FIFO port
    always @(negedge clk) begin
        if (rst_n && fifo_wr_valid) begin
            if (exp_rx.size() == 0) check({tag_rx, " unexpected fifo write"}, {24'd0, fifo_wr_data}, 32'hFFFF_FFFF);
            else check({tag_rx, " fifo write"}, {24'd0, fifo_wr_data}, {24'd0, exp_rx.pop_front()});
        end
    end

    // Monitor of the transmit shifter port
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) check({tag_tx, " unexpected tx char"}, {24'd0, tx_data}, 32'hFFFF_FFFF);
            else check({tag_tx, " tx char"}, {24'd0, tx_data}, {24'd0, exp_tx.pop_front()});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rx_char(input logic [W-1:0] b);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic pulse_halt();
        @(posedge clk); #1 halt_req = 1'b1;
        @(posedge clk); #1 halt_req = 1'b0;
    endtask

    task automatic pulse_resume();
        @(posedge clk); #1 resume_req = 1'b1;
        @(posedge clk); #1 resume_req = 1'b0;
    endtask

    task automatic wait_src_taken();
        forever begin
            @(negedge clk);
            if (src_ready) break;
        end
        @(posedge clk); #1 src_valid = 1'b0;
    endtask

    task automatic send_src(input logic [W-1:0] b);
        exp_tx.push_back(b);
        @(posedge clk); #1 src_valid = 1'b1; src_data = b;
        wait_src_taken();
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx_en", tx_en, 1);
        check("R1 tx_valid", tx_valid, 0);
        check("R1 fifo_wr_valid", fifo_wr_valid, 0);
        check("R1 xoff_irq", xoff_irq, 0);

        // R2: matching off, stop characters are plain data
        tag_rx = "R2";
        exp_rx.push_back(OFF1); rx_char(OFF1);
        exp_rx.push_back(8'h41); rx_char(8'h41);
        idle(2);
        check("R2 tx_en stays", tx_en, 1);

        // R3/R5: set 1, interrupt enabled
        tag_rx = "R3";
        cfg_mode = 4'b0010; xoff_irq_en = 1'b1;
        exp_rx.push_back(8'h42); rx_char(8'h42);
        exp_rx.push_back(OFF2); rx_char(OFF2);
        rx_char(OFF1);
        check("R3 stop match pauses", tx_en, 0);
        check("R5 irq pulse", xoff_irq, 1);
        idle(1);
        check("R5 irq one cycle", xoff_irq, 0);

        // R6: data held while paused
        tag_tx = "R6";
        exp_tx.push_back(8'h55);
        src_valid = 1'b1; src_data = 8'h55;
        repeat (3) begin
            @(negedge clk);
            check("R6 src_ready while paused", src_ready, 0);
            check("R6 tx_valid while paused", tx_valid, 0);
        end
        rx_char(ON1);
        check("R3 go match resumes", tx_en, 1);
        wait_src_taken();
        idle(2);

        // R3/R5: set 2, interrupt disabled
        cfg_mode = 4'b0001; xoff_irq_en = 1'b0;
        rx_char(OFF2);
        check("R3 set2 stop pauses", tx_en, 0);
        check("R5 irq disabled", xoff_irq, 0);
        exp_rx.push_back(OFF1); rx_char(OFF1);
        rx_char(ON2);
        check("R3 set2 go resumes", tx_en, 1);
        idle(2);

        // R4: paired matching
        tag_rx = "R4";
        cfg_mode = 4'b0011;
        rx_char(OFF1);
        check("R4 half pair no pause", tx_en, 1);
        rx_char(OFF2);
        check("R4 pair pauses", tx_en, 0);
        rx_char(ON1); rx_char(ON2);
        check("R4 pair resumes", tx_en, 1);
        exp_rx.push_back(OFF1); exp_rx.push_back(8'h43);
        rx_char(OFF1); rx_char(8'h43);
        idle(2);
        check("R4 broken pair no pause", tx_en, 1);
        exp_rx.push_back(ON1);
        rx_char(ON1); rx_char(OFF1); rx_char(OFF2);
        check("R4 pair after held go pauses", tx_en, 0);
        rx_char(ON1); rx_char(ON2);
        check("R4 resumed again", tx_en, 1);
        idle(3);

        // R7: insertion off
        tag_tx = "R7";
        cfg_mode = 4'b0000;
        pulse_halt();
        send_src(8'h20);
        pulse_resume();
        idle(3);

        // R8: set 1, stop goes ahead of a waiting byte
        tag_tx = "R8";
        cfg_mode = 4'b1000;
        tx_ready = 1'b0;
        exp_tx.push_back(OFF1); exp_tx.push_back(8'h21);
        @(posedge clk); #1 src_valid = 1'b1; src_data = 8'h21;
        pulse_halt();
        @(negedge clk);
        check("R8 stop offered first", tx_data, OFF1);
        @(posedge clk); #1 tx_ready = 1'b1;
        wait_src_taken();
        // R10: a second halt sends nothing
        tag_tx = "R10";
        pulse_halt();
        send_src(8'h22);
        exp_tx.push_back(ON1);
        pulse_resume();
        idle(3);
        pulse_resume();
        send_src(8'h23);
        idle(3);

        // R8: set 2
        tag_tx = "R8";
        cfg_mode = 4'b0100;
        exp_tx.push_back(OFF2); pulse_halt(); idle(3);
        exp_tx.push_back(ON2); pulse_resume(); idle(3);

        // R9: paired sending
        tag_tx = "R9";
        cfg_mode = 4'b1100;
        exp_tx.push_back(OFF1); exp_tx.push_back(OFF2);
        pulse_halt(); idle(4);
        exp_tx.push_back(ON1); exp_tx.push_back(ON2);
        pulse_resume(); idle(4);

        // R11: halt cancelled by resume before it is sent
        tag_tx = "R11";
        cfg_mode = 4'b1000;
        tx_ready = 1'b0;
        pulse_halt(); pulse_resume();
        @(posedge clk); #1 tx_ready = 1'b1;
        send_src(8'h24);
        idle(4);

        check("R2 rx queue drained", exp_rx.size(), 0);
        check("R8 tx queue drained", exp_tx.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule